// File: doc/BRIEF.md
# Configurable LUT-Based Distributed RAM Slice

This block is a small storage slice made of two 16-cell, one-bit lookup arrays. Its layout is chosen by a static mode input. In split mode it acts as two independent 16x1 RAMs. In wide mode it is one 32x1 RAM, and the second data input serves as the fifth address bit. In dual-port mode it is one 16x1 RAM with one write port and two read ports: the write goes to both arrays and each array is read at its own address.

Reads are combinational: a data output follows its addressed cell without waiting for a clock. Writes are synchronous. A static edge-select input picks which clock edge does the write, and an active-high write enable qualifies it. The contents start from a parameter value. The reset input never touches the stored bits.

Top module: `distram_slice`

## Requirements
- R1: With no active clock edge, `rd_a` follows cell `addr_a` of array 0 in split and dual-port modes. `rd_b` follows cell `addr_b` of array 1 in the same modes. Both change combinationally when the address changes.
- R2: Split mode (`cfg_mode` 2'b00 or 2'b11). On an active edge with `wr_en` high, cell `addr_a` of array 0 takes `din_a` and cell `addr_b` of array 1 takes `din_b`.
- R3: Wide mode (`cfg_mode` 2'b01). `din_b` selects the array (0 = array 0, 1 = array 1) and `addr_a` selects the cell. A write stores `din_a` into that one cell only. `rd_a` shows the selected cell and `rd_b` is held low.
- R4: Dual-port mode (`cfg_mode` 2'b10). A write stores `din_a` at `addr_a` in both arrays and ignores `din_b` and `addr_b`. `rd_b` reads array 1 at `addr_b`.
- R5: When a read address equals the write address, the output shows the old value up to the active edge and the new value after it.
- R6: With `wr_en` low, an active edge leaves every cell unchanged.
- R7: `cfg_fall` = 0 makes the rising edge the write edge and `cfg_fall` = 1 the falling edge. The other edge never writes. The setting applies to both arrays together.
- R8: At start, cell k of array 0 holds bit k of `INIT` and cell k of array 1 holds bit 16+k. `INIT` defaults to all zeros.
- R9: Asserting `rst` leaves the stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; does not alter the contents |
| cfg_fall | input | 1 | Static write-edge select: 0 rising, 1 falling |
| cfg_mode | input | 2 | Static layout: 00/11 split, 01 wide, 10 dual-port |
| wr_en | input | 1 | Active-high write enable |
| addr_a | input | 4 | Address bus A: array 0 read/write, shared write address |
| addr_b | input | 4 | Address bus B: array 1 address (split) or second read address (dual-port) |
| din_a | input | 1 | Write data A |
| din_b | input | 1 | Write data B, or fifth address bit in wide mode |
| rd_a | output | 1 | Read output A |
| rd_b | output | 1 | Read output B |

## Verification
The bench builds the slice with a non-zero `INIT` pattern, so that the start-up contents, and the fact that a reset leaves them in place, can be told apart from all-zero cells. It runs every mode, including the alternate split code, under both write-edge settings. In each operation it looks at the outputs before the inactive edge, after it, and after the active edge. This exposes read-before-write ordering and any write on the wrong edge.

// File: rtl/distram_pkg.sv
package distram_pkg;

    localparam int ADDR_W  = 4;
    localparam int CELLS   = 1 << ADDR_W;
    localparam int NUM_ARR = 2;
    localparam int TOTAL   = CELLS * NUM_ARR;

    typedef enum logic [1:0] {
        MODE_SPLIT     = 2'b00,
        MODE_WIDE      = 2'b01,
        MODE_DUAL      = 2'b10,
        MODE_SPLIT_ALT = 2'b11
    } mode_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic              data;
    } wr_port_t;

    function automatic mode_e decode_mode(input logic [1:0] raw);
        return mode_e'(raw);
    endfunction

    function automatic logic is_split(input mode_e m);
        return (m == MODE_SPLIT) || (m == MODE_SPLIT_ALT);
    endfunction

endpackage

// File: rtl/distram_cell_array.sv
module distram_cell_array
    import distram_pkg::*;
#(
    parameter logic [CELLS-1:0] INIT_BITS = '0
) (
    input  logic              wclk,
    input  logic              rst,
    input  wr_port_t          wr,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rdata
);

    logic [CELLS-1:0] mem = INIT_BITS;

    always_ff @(posedge wclk) begin
        if (wr.en) begin
            mem[wr.addr] <= wr.data;
        end
    end

    assign rdata = mem[raddr];

    // R5: an enabled write is visible at the following write edge
    assert_write_lands_R5: assert property (@(posedge wclk) disable iff (rst)
        wr.en |=> (mem[$past(wr.addr)] == $past(wr.data)));

    // R6: no enable, no change
    assert_hold_when_idle_R6: assert property (@(posedge wclk) disable iff (rst)
        !wr.en |=> $stable(mem));

endmodule

// File: rtl/distram_wr_ctrl.sv
module distram_wr_ctrl
    import distram_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  mode_e                    mode,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr_a,
    input  logic [ADDR_W-1:0]        addr_b,
    input  logic                     din_a,
    input  logic                     din_b,
    output wr_port_t [NUM_ARR-1:0]   wr
);

    always_comb begin
        wr = '0;
        unique case (mode)
            MODE_WIDE: begin
                for (int i = 0; i < NUM_ARR; i++) begin
                    wr[i].en   = we && (din_b == logic'(i));
                    wr[i].addr = addr_a;
                    wr[i].data = din_a;
                end
            end
            MODE_DUAL: begin
                for (int i = 0; i < NUM_ARR; i++) begin
                    wr[i].en   = we;
                    wr[i].addr = addr_a;
                    wr[i].data = din_a;
                end
            end
            default: begin
                wr[0].en   = we;
                wr[0].addr = addr_a;
                wr[0].data = din_a;
                wr[1].en   = we;
                wr[1].addr = addr_b;
                wr[1].data = din_b;
            end
        endcase
    end

    // R3: wide mode enables at most one array, and only when writing
    assert_wide_single_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WIDE) |-> ($onehot0({wr[1].en, wr[0].en}) &&
                                 ((wr[0].en || wr[1].en) == we)));

    // R4: dual-port mode mirrors one write into both arrays
    assert_dual_mirror_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DUAL) |-> ((wr[0] == wr[1]) && (wr[1].addr == addr_a) &&
                                 (wr[1].data == din_a)));

    // R2: split mode keeps each array on its own bus
    assert_split_own_bus_R2: assert property (@(posedge clk) disable iff (rst)
        is_split(mode) |-> ((wr[1].addr == addr_b) && (wr[1].data == din_b) &&
                            (wr[0].addr == addr_a)));

endmodule

// File: rtl/distram_rd_sel.sv
module distram_rd_sel
    import distram_pkg::*;
(
    input  mode_e                            mode,
    input  logic [ADDR_W-1:0]                addr_a,
    input  logic [ADDR_W-1:0]                addr_b,
    input  logic                             din_b,
    input  logic [NUM_ARR-1:0]               cell_q,
    output logic [NUM_ARR-1:0][ADDR_W-1:0]   raddr,
    output logic                             rd_a,
    output logic                             rd_b
);

    always_comb begin
        raddr[0] = addr_a;
        raddr[1] = (mode == MODE_WIDE) ? addr_a : addr_b;
    end

    always_comb begin
        if (mode == MODE_WIDE) begin
            rd_a = din_b ? cell_q[1] : cell_q[0];
            rd_b = 1'b0;
        end else begin
            rd_a = cell_q[0];
            rd_b = cell_q[1];
        end
    end

endmodule

// File: rtl/distram_slice.sv
module distram_slice
    import distram_pkg::*;
#(
    parameter logic [TOTAL-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_fall,
    input  logic [1:0]        cfg_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              din_a,
    input  logic              din_b,
    output logic              rd_a,
    output logic              rd_b
);

    mode_e                           mode;
    logic                            wclk;
    wr_port_t [NUM_ARR-1:0]          wr;
    logic [NUM_ARR-1:0][ADDR_W-1:0]  raddr;
    logic [NUM_ARR-1:0]              cell_q;

    assign mode = decode_mode(cfg_mode);
    assign wclk = clk ^ cfg_fall;

    distram_wr_ctrl u_wr (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .we     (wr_en),
        .addr_a (addr_a),
        .addr_b (addr_b),
        .din_a  (din_a),
        .din_b  (din_b),
        .wr     (wr)
    );

    for (genvar g = 0; g < NUM_ARR; g++) begin : g_arr
        distram_cell_array #(
            .INIT_BITS (INIT[g*CELLS +: CELLS])
        ) u_cells (
            .wclk  (wclk),
            .rst   (rst),
            .wr    (wr[g]),
            .raddr (raddr[g]),
            .rdata (cell_q[g])
        );
    end

    distram_rd_sel u_rd (
        .mode   (mode),
        .addr_a (addr_a),
        .addr_b (addr_b),
        .din_b  (din_b),
        .cell_q (cell_q),
        .raddr  (raddr),
        .rd_a   (rd_a),
        .rd_b   (rd_b)
    );

    // R3: second output is parked low in wide mode
    assert_wide_rd_b_low_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WIDE) |-> !rd_b);

endmodule

// File: tb/distram_slice_test.sv
`timescale 1ns/1ps
module distram_slice_test;

    localparam logic [31:0] INIT_V = 32'h3C5A_96E1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_fall = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic       wr_en = 1'b0;
    logic [3:0] addr_a = '0;
    logic [3:0] addr_b = '0;
    logic       din_a = 1'b0;
    logic       din_b = 1'b0;
    logic       rd_a, rd_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [15:0] m0, m1;

    always #10 clk = ~clk;

    distram_slice #(.INIT(INIT_V)) uut (
        .clk(clk), .rst(rst), .cfg_fall(cfg_fall), .cfg_mode(cfg_mode),
        .wr_en(wr_en), .addr_a(addr_a), .addr_b(addr_b),
        .din_a(din_a), .din_b(din_b), .rd_a(rd_a), .rd_b(rd_b)
    );

    function automatic logic exp_a(input logic [1:0] m, input logic [3:0] aa,
                                   input logic d1);
        if (m == 2'b01) return d1 ? m1[aa] : m0[aa];
        return m0[aa];
    endfunction

    function automatic logic exp_b(input logic [1:0] m, input logic [3:0] ab);
        if (m == 2'b01) return 1'b0;
        return m1[ab];
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic wait_act();
        if (cfg_fall) @(negedge clk); else @(posedge clk);
    endtask

    task automatic wait_inact();
        if (cfg_fall) @(posedge clk); else @(negedge clk);
    endtask

    task automatic set_edge(input logic e);
        wr_en = 1'b0;
        cfg_fall = e;
        wait_act();
        #2;
    endtask

    // one operation, entered and left 2 ns after an active edge
    task automatic op(input logic [1:0] m, input logic w, input logic [3:0] aa,
                      input logic [3:0] ab, input logic d0, input logic d1);
        string post;
        cfg_mode = m; wr_en = w; addr_a = aa; addr_b = ab; din_a = d0; din_b = d1;
        #1;
        chk("R5 old value before edge A", rd_a, exp_a(m, aa, d1));
        chk("R5 old value before edge B", rd_b, exp_b(m, ab));
        wait_inact();
        #2;
        chk("R7 no write on inactive edge A", rd_a, exp_a(m, aa, d1));
        chk("R7 no write on inactive edge B", rd_b, exp_b(m, ab));
        wait_act();
        #2;
        if (w) begin
            case (m)
                2'b01: if (d1) m1[aa] = d0; else m0[aa] = d0;
                2'b10: begin m0[aa] = d0; m1[aa] = d0; end
                default: begin m0[aa] = d0; m1[ab] = d1; end
            endcase
        end
        if (!w)            post = "R6 idle edge";
        else if (m == 2'b01) post = "R3 wide write";
        else if (m == 2'b10) post = "R4 dual write";
        else               post = "R2 split write";
        chk({post, " A"}, rd_a, exp_a(m, aa, d1));
        chk({post, " B"}, rd_b, exp_b(m, ab));
    endtask

    task automatic scan(input string tag);
        wr_en = 1'b0;
        cfg_mode = 2'b00;
        for (int k = 0; k < 16; k++) begin
            addr_a = 4'(k); addr_b = 4'(15 - k);
            #1;
            chk({tag, " array0"}, rd_a, m0[k]);
            chk({tag, " array1"}, rd_b, m1[15 - k]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        m0 = INIT_V[15:0];
        m1 = INIT_V[31:16];
        repeat (3) @(posedge clk);
        #2;
        // R8: initial contents, read while reset is still high
        scan("R8 init contents");
        rst = 1'b0;
        wait_act();
        #2;
        // R1: combinational read, no edge in between
        cfg_mode = 2'b10;
        addr_a = 4'd0; addr_b = 4'd5; #1;
        chk("R1 comb read A", rd_a, m0[0]);
        chk("R1 comb read B", rd_b, m1[5]);
        addr_a = 4'd7; addr_b = 4'd14; #1;
        chk("R1 comb read A moved", rd_a, m0[7]);
        chk("R1 comb read B moved", rd_b, m1[14]);
        wait_act(); #2;
        // directed: same-address write/read in each mode
        op(2'b00, 1'b1, 4'd3, 4'd3, ~m0[3], ~m1[3]);
        op(2'b10, 1'b1, 4'd9, 4'd9, ~m1[9], 1'b0);
        op(2'b10, 1'b1, 4'd2, 4'd11, 1'b1, 1'b0);
        op(2'b01, 1'b1, 4'd4, 4'd0, ~m1[4], 1'b1);
        op(2'b01, 1'b1, 4'd4, 4'd0, ~m0[4], 1'b0);
        op(2'b11, 1'b1, 4'd15, 4'd0, 1'b0, 1'b1);
        op(2'b00, 1'b0, 4'd3, 4'd3, 1'b1, 1'b1);
        // falling edge
        set_edge(1'b1);
        op(2'b00, 1'b1, 4'd6, 4'd8, ~m0[6], ~m1[8]);
        op(2'b01, 1'b1, 4'd12, 4'd0, ~m1[12], 1'b1);
        op(2'b10, 1'b1, 4'd13, 4'd13, ~m0[13], 1'b1);
        // constrained random across both edges and all mode codes
        for (int e = 0; e < 2; e++) begin
            set_edge(logic'(e));
            for (int i = 0; i < 300; i++) begin
                op(2'($urandom % 4), logic'(($urandom % 4) != 0),
                   4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
            end
        end
        scan("R2 R3 R4 contents after random");
        // R9: reset pulse keeps contents
        set_edge(1'b0);
        rst = 1'b1;
        repeat (4) @(posedge clk);
        #2;
        rst = 1'b0;
        scan("R9 contents after reset");
        finish_run();
    end

endmodule